// File: doc/BRIEF.md
# Split Register Rename Map

This block is the register alias table of an out-of-order core. One architectural index space is cut into three regions: the low indices name integer registers, the indices directly above name floating-point registers, and everything above both names miscellaneous registers, which are never renamed. Integer and floating-point registers each keep their own table of physical tags. Miscellaneous registers get a fixed tag: their distance above the renamable range, plus the total count of physical registers.

A rename request is a valid/ready handshake. The new and previous tags come back combinationally in the cycle the request is accepted. `ren_ready` depends only on the region of `ren_arch` and on the matching free-list count. The requester holds `ren_valid` and `ren_arch` steady while `ren_ready` is low. Nothing is popped and no table entry changes until the cycle in which both are high. Each free list is an external pop/grant pair with an occupancy count: the grant tag must be valid whenever the count is nonzero, and a pop is issued only in the cycle the rename completes. A combinational lookup port reads the table. A direct entry-write port reloads entries during recovery. The block also reports how many renames can proceed.

Top module: `rat_rename_map`

## Requirements
- R1: An index below `NUM_LINT` selects the integer table. An index from `NUM_LINT` up to `NUM_LINT+NUM_LFP-1` selects the floating-point table. Lookup of either region returns the stored entry.
- R2: After reset, integer entry i holds `INT_BASE+i`, and floating-point entry j (index `NUM_LINT+j`) holds `FP_BASE+j`.
- R3: An accepted rename of a non-pinned integer or floating-point index returns the old entry as the previous tag and the matching free list's grant as the new tag. It raises that list's pop for exactly that cycle, and the table holds the grant from the next cycle on.
- R4: A rename of index `INT_ZERO` is always ready and pops nothing. It returns `INT_ZERO` as both tags and leaves the table unchanged.
- R5: With `FP_ZERO_PIN` set, a rename of index `FP_ZERO` is always ready and pops nothing. It returns `FP_ZERO` as the new tag and the stored entry as the previous tag, and leaves the table unchanged.
- R6: A rename of a miscellaneous index k is always ready and pops nothing. Both tags equal `k - (NUM_LINT+NUM_LFP) + NUM_PINT + NUM_PFP`.
- R7: Lookup of a miscellaneous index returns the same fixed tag as R6. Lookup reflects the table before any write made in the same cycle.
- R8: A direct write updates the addressed integer or floating-point entry on the next edge. A write to a miscellaneous index has no effect. When a direct write and an accepted rename hit the same entry in the same cycle, the direct write's tag is kept.
- R9: `avail_cnt` equals the smaller of `int_free_cnt` and `fp_free_cnt`.
- R10: `ren_tag_err` is high in a cycle with an integer pop whose grant is not below `NUM_PINT`. It is also high in a cycle with a floating-point pop whose grant lies outside `NUM_PINT` to `NUM_PINT+NUM_PFP-1`. It is low otherwise.
- R11: A non-pinned rename whose free-list count is zero sees `ren_ready` low, pops nothing, and leaves the table unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ren_valid | input | 1 | Rename request present |
| ren_ready | output | 1 | Rename can complete this cycle |
| ren_arch | input | AW | Architectural index to rename |
| ren_new_tag | output | TW | Newly assigned physical tag |
| ren_prev_tag | output | TW | Tag the index held before the rename |
| ren_tag_err | output | 1 | Granted tag lies outside its class range |
| int_pop | output | 1 | Take the integer grant |
| int_grant_tag | input | TW | Head of the integer free list |
| int_free_cnt | input | CW | Integer free-list occupancy |
| fp_pop | output | 1 | Take the floating-point grant |
| fp_grant_tag | input | TW | Head of the floating-point free list |
| fp_free_cnt | input | CW | Floating-point free-list occupancy |
| lk_arch | input | AW | Index to look up |
| lk_tag | output | TW | Current tag of `lk_arch` |
| wr_en | input | 1 | Direct entry write enable |
| wr_arch | input | AW | Index to overwrite |
| wr_tag | input | TW | Tag to store |
| avail_cnt | output | CW | Renames that can proceed |

## Verification
The bench builds the block with four integer and four floating-point logical registers, eight physical tags per class, two miscellaneous registers, index 0 as the integer zero and index 4 as the pinned floating-point zero. With only four free tags per class, a handful of renames drains a list. That brings stalls, refills, count minima and both pinned indices within reach in a short run. The small tag width also lets the bench inject grants from the wrong class to trigger the range flag.

// File: rtl/rat_pkg.sv
package rat_pkg;
  typedef enum logic [1:0] {
    RC_INT  = 2'd0,
    RC_FP   = 2'd1,
    RC_MISC = 2'd2
  } reg_class_e;
endpackage

// File: rtl/rat_reg_classify.sv
module rat_reg_classify
  import rat_pkg::*;
#(
  parameter int AW          = 7,
  parameter int NUM_LINT    = 32,
  parameter int NUM_LFP     = 32,
  parameter int INT_ZERO    = 31,
  parameter int FP_ZERO     = 63,
  parameter bit FP_ZERO_PIN = 1'b1
) (
  input  logic [AW-1:0] arch,
  output reg_class_e    cls,
  output logic          pinned
);
  localparam logic [AW-1:0] LIM_INT = AW'(NUM_LINT);
  localparam logic [AW-1:0] LIM_ALL = AW'(NUM_LINT + NUM_LFP);
  localparam logic [AW-1:0] IZ      = AW'(INT_ZERO);
  localparam logic [AW-1:0] FZ      = AW'(FP_ZERO);

  always_comb begin
    if (arch < LIM_INT) begin
      cls    = RC_INT;
      pinned = (arch == IZ);
    end else if (arch < LIM_ALL) begin
      cls    = RC_FP;
      pinned = FP_ZERO_PIN && (arch == FZ);
    end else begin
      cls    = RC_MISC;
      pinned = 1'b0;
    end
  end
endmodule

// File: rtl/rat_map_bank.sv
module rat_map_bank #(
  parameter int N    = 32,
  parameter int TW   = 7,
  parameter int BASE = 0,
  localparam int IW  = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [IW-1:0] rd_a_idx,
  output logic [TW-1:0] rd_a_tag,
  input  logic [IW-1:0] rd_b_idx,
  output logic [TW-1:0] rd_b_tag,
  input  logic          rn_en,
  input  logic [IW-1:0] rn_idx,
  input  logic [TW-1:0] rn_tag,
  input  logic          fx_en,
  input  logic [IW-1:0] fx_idx,
  input  logic [TW-1:0] fx_tag
);
  logic [TW-1:0] tbl [N];

  assign rd_a_tag = (32'(rd_a_idx) < N) ? tbl[rd_a_idx] : '0;
  assign rd_b_tag = (32'(rd_b_idx) < N) ? tbl[rd_b_idx] : '0;

  // Recovery write is applied last so it wins on a shared entry.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < N; i++) tbl[i] <= TW'(BASE + i);
    end else begin
      if (rn_en && 32'(rn_idx) < N) tbl[rn_idx] <= rn_tag;
      if (fx_en && 32'(fx_idx) < N) tbl[fx_idx] <= fx_tag;
    end
  end
endmodule

// File: rtl/rat_rename_map.sv
module rat_rename_map
  import rat_pkg::*;
#(
  parameter int NUM_LINT    = 32,
  parameter int NUM_LFP     = 32,
  parameter int NUM_PINT    = 64,
  parameter int NUM_PFP     = 64,
  parameter int NUM_MISC    = 8,
  parameter int INT_BASE    = 0,
  parameter int FP_BASE     = NUM_PINT,
  parameter int INT_ZERO    = 31,
  parameter int FP_ZERO     = NUM_LINT + 31,
  parameter bit FP_ZERO_PIN = 1'b1,
  parameter int CW          = 7,
  localparam int NL         = NUM_LINT + NUM_LFP,
  localparam int NP         = NUM_PINT + NUM_PFP,
  localparam int AW         = $clog2(NL + NUM_MISC),
  localparam int TW         = $clog2(NP + NUM_MISC)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ren_valid,
  output logic          ren_ready,
  input  logic [AW-1:0] ren_arch,
  output logic [TW-1:0] ren_new_tag,
  output logic [TW-1:0] ren_prev_tag,
  output logic          ren_tag_err,
  output logic          int_pop,
  input  logic [TW-1:0] int_grant_tag,
  input  logic [CW-1:0] int_free_cnt,
  output logic          fp_pop,
  input  logic [TW-1:0] fp_grant_tag,
  input  logic [CW-1:0] fp_free_cnt,
  input  logic [AW-1:0] lk_arch,
  output logic [TW-1:0] lk_tag,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_arch,
  input  logic [TW-1:0] wr_tag,
  output logic [CW-1:0] avail_cnt
);
  localparam int IIW = (NUM_LINT > 1) ? $clog2(NUM_LINT) : 1;
  localparam int FIW = (NUM_LFP > 1) ? $clog2(NUM_LFP) : 1;
  localparam logic [AW-1:0] LIM_INT = AW'(NUM_LINT);
  localparam logic [TW-1:0] PI_TAG  = TW'(NUM_PINT);
  localparam logic [TW-1:0] PT_TAG  = TW'(NP);
  localparam logic [TW-1:0] IZ_TAG  = TW'(INT_ZERO);
  localparam logic [TW-1:0] FZ_TAG  = TW'(FP_ZERO);

  reg_class_e rn_cls, lk_cls, wr_cls;
  logic       rn_pin, lk_pin, wr_pin;

  rat_reg_classify #(.AW(AW), .NUM_LINT(NUM_LINT), .NUM_LFP(NUM_LFP),
    .INT_ZERO(INT_ZERO), .FP_ZERO(FP_ZERO), .FP_ZERO_PIN(FP_ZERO_PIN))
    u_cls_rn (.arch(ren_arch), .cls(rn_cls), .pinned(rn_pin));
  rat_reg_classify #(.AW(AW), .NUM_LINT(NUM_LINT), .NUM_LFP(NUM_LFP),
    .INT_ZERO(INT_ZERO), .FP_ZERO(FP_ZERO), .FP_ZERO_PIN(FP_ZERO_PIN))
    u_cls_lk (.arch(lk_arch), .cls(lk_cls), .pinned(lk_pin));
  rat_reg_classify #(.AW(AW), .NUM_LINT(NUM_LINT), .NUM_LFP(NUM_LFP),
    .INT_ZERO(INT_ZERO), .FP_ZERO(FP_ZERO), .FP_ZERO_PIN(FP_ZERO_PIN))
    u_cls_wr (.arch(wr_arch), .cls(wr_cls), .pinned(wr_pin));

  function automatic logic [TW-1:0] misc_tag(input logic [AW-1:0] a);
    return TW'(32'(a) + 32'(NP - NL));
  endfunction

  logic [TW-1:0] int_lk_tag, int_rn_tag, fp_lk_tag, fp_rn_tag;
  logic          int_has, fp_has;

  assign int_has = (int_free_cnt != '0);
  assign fp_has  = (fp_free_cnt != '0);

  always_comb begin
    ren_ready    = 1'b1;
    int_pop      = 1'b0;
    fp_pop       = 1'b0;
    ren_new_tag  = misc_tag(ren_arch);
    ren_prev_tag = misc_tag(ren_arch);
    unique case (rn_cls)
      RC_INT: begin
        if (rn_pin) begin
          ren_new_tag  = IZ_TAG;
          ren_prev_tag = IZ_TAG;
        end else begin
          ren_ready    = int_has;
          int_pop      = ren_valid && int_has;
          ren_new_tag  = int_grant_tag;
          ren_prev_tag = int_rn_tag;
        end
      end
      RC_FP: begin
        ren_prev_tag = fp_rn_tag;
        if (rn_pin) begin
          ren_new_tag = FZ_TAG;
        end else begin
          ren_ready   = fp_has;
          fp_pop      = ren_valid && fp_has;
          ren_new_tag = fp_grant_tag;
        end
      end
      default: ;
    endcase
  end

  assign ren_tag_err = (int_pop && (int_grant_tag >= PI_TAG)) ||
                       (fp_pop && ((fp_grant_tag < PI_TAG) || (fp_grant_tag >= PT_TAG)));

  always_comb begin
    unique case (lk_cls)
      RC_INT:  lk_tag = int_lk_tag;
      RC_FP:   lk_tag = fp_lk_tag;
      default: lk_tag = misc_tag(lk_arch);
    endcase
  end

  assign avail_cnt = (int_free_cnt < fp_free_cnt) ? int_free_cnt : fp_free_cnt;

  rat_map_bank #(.N(NUM_LINT), .TW(TW), .BASE(INT_BASE)) u_int_bank (
    .clk(clk), .rst_n(rst_n),
    .rd_a_idx(IIW'(lk_arch)),   .rd_a_tag(int_lk_tag),
    .rd_b_idx(IIW'(ren_arch)),  .rd_b_tag(int_rn_tag),
    .rn_en(int_pop),            .rn_idx(IIW'(ren_arch)), .rn_tag(int_grant_tag),
    .fx_en(wr_en && wr_cls == RC_INT), .fx_idx(IIW'(wr_arch)), .fx_tag(wr_tag)
  );

  rat_map_bank #(.N(NUM_LFP), .TW(TW), .BASE(FP_BASE)) u_fp_bank (
    .clk(clk), .rst_n(rst_n),
    .rd_a_idx(FIW'(lk_arch - LIM_INT)),  .rd_a_tag(fp_lk_tag),
    .rd_b_idx(FIW'(ren_arch - LIM_INT)), .rd_b_tag(fp_rn_tag),
    .rn_en(fp_pop), .rn_idx(FIW'(ren_arch - LIM_INT)), .rn_tag(fp_grant_tag),
    .fx_en(wr_en && wr_cls == RC_FP), .fx_idx(FIW'(wr_arch - LIM_INT)), .fx_tag(wr_tag)
  );
endmodule

// File: rtl/rat_rename_checker.sv
module rat_rename_checker #(
  parameter int NUM_LINT = 32,
  parameter int NUM_LFP  = 32,
  parameter int INT_ZERO = 31,
  parameter int AW       = 7,
  parameter int TW       = 7,
  parameter int CW       = 7
) (
  input logic          clk,
  input logic          rst_n,
  input logic          ren_valid,
  input logic          ren_ready,
  input logic [AW-1:0] ren_arch,
  input logic [TW-1:0] ren_new_tag,
  input logic [TW-1:0] ren_prev_tag,
  input logic          ren_tag_err,
  input logic          int_pop,
  input logic          fp_pop,
  input logic [CW-1:0] int_free_cnt,
  input logic [CW-1:0] fp_free_cnt,
  input logic [CW-1:0] avail_cnt
);
  localparam logic [AW-1:0] LIM_ALL = AW'(NUM_LINT + NUM_LFP);
  localparam logic [AW-1:0] IZ      = AW'(INT_ZERO);

  assert_pop_on_handshake_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (int_pop || fp_pop) |-> (ren_valid && ren_ready && !(int_pop && fp_pop)));

  assert_int_zero_pinned_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (ren_valid && ren_arch == IZ) |->
      (ren_ready && !int_pop && ren_new_tag == TW'(INT_ZERO) && ren_prev_tag == TW'(INT_ZERO)));

  assert_misc_fixed_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (ren_valid && ren_arch >= LIM_ALL) |->
      (ren_ready && !int_pop && !fp_pop && ren_new_tag == ren_prev_tag));

  assert_avail_min_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (avail_cnt <= int_free_cnt) && (avail_cnt <= fp_free_cnt) &&
    ((avail_cnt == int_free_cnt) || (avail_cnt == fp_free_cnt)));

  assert_err_needs_pop_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ren_tag_err |-> (int_pop || fp_pop));

  assert_stall_no_pop_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (ren_valid && !ren_ready) |-> (!int_pop && !fp_pop));
endmodule

bind rat_rename_map rat_rename_checker #(
  .NUM_LINT(NUM_LINT), .NUM_LFP(NUM_LFP), .INT_ZERO(INT_ZERO),
  .AW(AW), .TW(TW), .CW(CW)
) u_rat_chk (
  .clk(clk), .rst_n(rst_n), .ren_valid(ren_valid), .ren_ready(ren_ready),
  .ren_arch(ren_arch), .ren_new_tag(ren_new_tag), .ren_prev_tag(ren_prev_tag),
  .ren_tag_err(ren_tag_err), .int_pop(int_pop), .fp_pop(fp_pop),
  .int_free_cnt(int_free_cnt), .fp_free_cnt(fp_free_cnt), .avail_cnt(avail_cnt)
);

// File: tb/test_rat_rename_map.sv
module test_rat_rename_map;
  localparam int CLK_P = 10;
  localparam int NLI = 4, NLF = 4, NPI = 8, NPF = 8, NMS = 2;
  localparam int IZ = 0, FZ = 4;
  localparam int NL = NLI + NLF, NP = NPI + NPF;
  localparam int AW = $clog2(NL + NMS), TW = $clog2(NP + NMS), CW = 5;

  logic clk = 1'b0, rst_n = 1'b0;
  logic ren_valid = 1'b0, ren_ready, ren_tag_err, int_pop, fp_pop, wr_en = 1'b0;
  logic [AW-1:0] ren_arch = '0, lk_arch = '0, wr_arch = '0;
  logic [TW-1:0] ren_new_tag, ren_prev_tag, int_grant_tag = '0, fp_grant_tag = '0;
  logic [TW-1:0] lk_tag, wr_tag = '0;
  logic [CW-1:0] int_free_cnt = '0, fp_free_cnt = '0, avail_cnt;

  always #(CLK_P/2) clk = ~clk;

  rat_rename_map #(.NUM_LINT(NLI), .NUM_LFP(NLF), .NUM_PINT(NPI), .NUM_PFP(NPF),
    .NUM_MISC(NMS), .INT_BASE(0), .FP_BASE(NPI), .INT_ZERO(IZ), .FP_ZERO(FZ),
    .FP_ZERO_PIN(1'b1), .CW(CW)) i_rat_rename_map (
    .clk(clk), .rst_n(rst_n), .ren_valid(ren_valid), .ren_ready(ren_ready),
    .ren_arch(ren_arch), .ren_new_tag(ren_new_tag), .ren_prev_tag(ren_prev_tag),
    .ren_tag_err(ren_tag_err), .int_pop(int_pop), .int_grant_tag(int_grant_tag),
    .int_free_cnt(int_free_cnt), .fp_pop(fp_pop), .fp_grant_tag(fp_grant_tag),
    .fp_free_cnt(fp_free_cnt), .lk_arch(lk_arch), .lk_tag(lk_tag), .wr_en(wr_en),
    .wr_arch(wr_arch), .wr_tag(wr_tag), .avail_cnt(avail_cnt));

  int n_cmp = 0, n_bad = 0;
  int m[NL];
  int iq[$], fq[$], retired[$];
  bit bad_i = 0, bad_f = 0;

  task automatic chk(input string rq, input string what, input int got, input int exp);
    n_cmp++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s %s: got %0d expected %0d", rq, what, got, exp);
    end
  endtask

  task automatic step(input bit v, input int a, input bit we, input int wa, input int wt,
                      input int la, input string rq, input string lq);
    int gi, gf, en, ep, el, ea;
    bit er, ei, ef, ee;
    gi = bad_i ? 9 : (iq.size() > 0 ? iq[0] : 0);
    gf = bad_f ? 3 : (fq.size() > 0 ? fq[0] : 0);
    ren_valid = v; ren_arch = AW'(a); wr_en = we; wr_arch = AW'(wa); wr_tag = TW'(wt);
    lk_arch = AW'(la); int_grant_tag = TW'(gi); fp_grant_tag = TW'(gf);
    int_free_cnt = CW'(bad_i ? 1 : iq.size()); fp_free_cnt = CW'(bad_f ? 1 : fq.size());
    #1;
    ei = 0; ef = 0; ee = 0;
    if (a < NLI) begin
      if (a == IZ) begin er = 1; en = IZ; ep = IZ; end
      else begin er = int_free_cnt != 0; en = gi; ep = m[a]; ei = er; ee = gi >= NPI; end
    end else if (a < NL) begin
      ep = m[a];
      if (a == FZ) begin er = 1; en = FZ; end
      else begin er = fp_free_cnt != 0; en = gf; ef = er; ee = (gf < NPI) || (gf >= NP); end
    end else begin er = 1; en = a - NL + NP; ep = en; end
    ei &= v; ef &= v; ee = ee && (ei || ef);
    chk(rq, "ready", ren_ready, er);
    if (er) begin
      chk(rq, "new_tag", ren_new_tag, en);
      chk(rq, "prev_tag", ren_prev_tag, ep);
    end
    chk(rq, "int_pop", int_pop, ei);
    chk(rq, "fp_pop", fp_pop, ef);
    chk("R10", "tag_err", ren_tag_err, ee);
    el = (la < NL) ? m[la] : la - NL + NP;
    chk(lq, "lookup", lk_tag, el);
    ea = (int_free_cnt < fp_free_cnt) ? int_free_cnt : fp_free_cnt;
    chk("R9", "avail", avail_cnt, ea);
    @(posedge clk); #1;
    if (ei) begin m[a] = gi; if (!bad_i) void'(iq.pop_front()); retired.push_back(ep); end
    if (ef) begin m[a] = gf; if (!bad_f) void'(fq.pop_front()); end
    if (we && wa < NL) m[wa] = wt;
  endtask

  initial begin
    #(CLK_P * 100000);
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < NLI; i++) m[i] = i;
    for (int j = 0; j < NLF; j++) m[NLI + j] = NPI + j;
    for (int t = NLI; t < NPI; t++) iq.push_back(t);
    for (int t = NPI + NLF; t < NP; t++) fq.push_back(t);
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    // R2 reset image, R1/R7 lookup of every region
    for (int a = 0; a < NL + NMS; a++) step(0, 1, 0, 0, 0, a, "R2", (a < NL) ? "R2" : "R7");
    // R3 integer renames; lookup shows pre-write state (R7) then new value (R1)
    step(1, 1, 0, 0, 0, 1, "R3", "R7");
    step(1, 2, 0, 0, 0, 1, "R3", "R1");
    step(1, 3, 0, 0, 0, 2, "R3", "R1");
    step(1, 0, 0, 0, 0, 0, "R4", "R4");
    step(1, 0, 0, 0, 0, 3, "R4", "R1");
    // R3 float renames, R5 pinned float zero
    step(1, 5, 0, 0, 0, 5, "R3", "R7");
    step(1, 6, 0, 0, 0, 5, "R3", "R1");
    step(1, 4, 0, 0, 0, 4, "R5", "R5");
    step(1, 4, 0, 0, 0, 4, "R5", "R5");
    // R6 misc renames
    step(1, 8, 0, 0, 0, 8, "R6", "R7");
    step(1, 9, 0, 0, 0, 9, "R6", "R7");
    // R8 direct writes, misc write ignored, write wins over same-cycle rename
    step(0, 1, 1, 1, 7, 1, "R8", "R8");
    step(0, 1, 1, 6, 2, 1, "R8", "R8");
    step(0, 1, 1, 9, 3, 6, "R8", "R8");
    step(0, 1, 0, 0, 0, 9, "R8", "R8");
    step(1, 7, 1, 7, 5, 7, "R8", "R8");
    step(0, 1, 0, 0, 0, 7, "R8", "R8");
    // R11 drain integer list (R3 consumes the last tag), then stall
    step(1, 2, 0, 0, 0, 2, "R3", "R1");
    step(1, 3, 0, 0, 0, 3, "R11", "R11");
    step(1, 3, 0, 0, 0, 3, "R11", "R11");
    step(1, 0, 0, 0, 0, 3, "R4", "R11");
    // refill from retired tags, retry
    while (retired.size() > 0) iq.push_back(retired.pop_front());
    step(1, 3, 0, 0, 0, 3, "R3", "R7");
    step(0, 3, 0, 0, 0, 3, "R3", "R1");
    // R10 out-of-range grants
    bad_i = 1; step(1, 2, 0, 0, 0, 2, "R10", "R1"); bad_i = 0;
    bad_f = 1; step(1, 7, 0, 0, 0, 7, "R10", "R1"); bad_f = 0;
    step(0, 1, 0, 0, 0, 2, "R10", "R1");
    step(0, 1, 0, 0, 0, 7, "R10", "R1");
    // R9 with the float list drained
    while (fq.size() > 0) step(1, 6, 0, 0, 0, 6, "R9", "R1");
    step(1, 5, 0, 0, 0, 5, "R11", "R11");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule